// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the configuration front end of a multi-function peripheral chip that sits in legacy byte-wide I/O space. It watches two adjacent port addresses, an index port at the base and a data port one above it. The base is one of two fixed values, picked by a strap pin. Configuration access stays locked until the host writes an entry key twice in a row to the index port. While unlocked, the host writes a register number to the index port and then reads or writes that register through the data port. A single exit key locks the block again.

Register numbers below 0x30 are global. They hold the logical-device selector, a read-only 16-bit chip identifier, and a small bank of writable global bytes that the rest of the chip sees on a parallel output. Register numbers at 0x30 and above are banked. The logical-device number picks one of several per-device register files, which sit behind a one-hot select, address, data and strobe bus. The read path is combinational, so read data is valid in the same cycle as the read strobe.

Top module: `cfg_port_ctrl`

## Requirements
- R1: Configuration access opens only after two back-to-back writes of 0x87 to the index port. After one 0x87, the data port still acts locked. Data-port accesses between the two key writes do not break the sequence.
- R2: In the half-unlocked state, an index-port write of any value other than 0x87 drops the block back to fully locked, and two fresh 0x87 writes are then needed.
- R3: While open, an index-port write of 0xAA locks the block and does not change the held register number. After re-entry, the data port reaches the register that was selected before the exit.
- R4: While locked, data-port reads return 0xFF, and data-port writes and non-key index-port writes change no register.
- R5: Strap low places the index and data ports at 0x2E and 0x2F. Strap high places them at 0x4E and 0x4F. Accesses to any other address have no effect, and reads there return 0xFF. Index-port reads return 0xFF.
- R6: After reset the block is locked, the register number is 0x00 and the logical-device number is 0x00.
- R7: Register 0x20 reads 0xA2 and register 0x21 reads 0x32. Together they form the identifier 0xA232: family 0xA23 in the upper 12 bits and revision 2 in the low nibble. Writes to these two registers are ignored.
- R8: Register 0x07 is read/write and holds the logical-device number.
- R9: Registers 0x22 to 0x2F are read/write bytes that appear on `glb_cfg`, with register 0x22+k at bits [8k+7:8k]. All other global numbers, apart from 0x07, 0x20 and 0x21, read 0x00 and ignore writes.
- R10: With logical device 7+k selected (k = 0, 1, 2) and the block open, a register number of 0x30 or above drives `dev_sel` bit k alone and places the number on `dev_addr`. A data write pulses `dev_wr` with the byte on `dev_wdata`. A data read pulses `dev_rd` and returns `dev_rdata[8k+7:8k]` in the same cycle.
- R11: If the logical-device number selects no implemented device, register numbers of 0x30 and above read 0xFF, and `dev_sel`, `dev_wr` and `dev_rd` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_hi | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Byte write strobe, one cycle |
| io_rd | input | 1 | Byte read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0xFF when nothing answers |
| glb_cfg | output | 112 | Writable global bytes 0x22 to 0x2F |
| dev_sel | output | 3 | One-hot logical device select |
| dev_addr | output | 8 | Banked register number |
| dev_wr | output | 1 | Banked write strobe |
| dev_rd | output | 1 | Banked read strobe |
| dev_wdata | output | 8 | Banked write data |
| dev_rdata | input | 24 | Read data from each device, device k at bits [8k+7:8k] |

## Verification
The hardest situations to reach are the partial-key states. One is the half-unlocked state hit by a wrong byte. The other is a lock and re-entry that has to keep the old register number. Neither can be seen directly at the ports. The stimulus therefore interleaves key bytes, stray bytes and data-port probes, and infers the lock state from whether a later data read returns the selected register or 0xFF. The bench also moves the strap while the block is open, then sends the exit key to the address that is no longer decoded, to show the lock survives it.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_ENTER  = 8'h87;
  localparam logic [7:0] KEY_EXIT   = 8'hAA;
  localparam logic [7:0] REG_LDN    = 8'h07;
  localparam logic [7:0] REG_ID_HI  = 8'h20;
  localparam logic [7:0] REG_ID_LO  = 8'h21;
  localparam logic [7:0] BANK_START = 8'h30;
  localparam logic [7:0] NO_DATA    = 8'hFF;

  function automatic logic [15:0] port_base(input logic strap,
                                            input logic [15:0] lo,
                                            input logic [15:0] hi);
    return strap ? hi : lo;
  endfunction

  function automatic key_state_e next_key(input key_state_e s,
                                          input logic [7:0] d);
    case (s)
      KS_LOCKED: return (d == KEY_ENTER) ? KS_HALF : KS_LOCKED;
      KS_HALF:   return (d == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
      KS_OPEN:   return (d == KEY_EXIT) ? KS_LOCKED : KS_OPEN;
      default:   return KS_LOCKED;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [11:0] fam,
                                         input logic [3:0] rev,
                                         input logic hi);
    logic [15:0] id;
    id = {fam, rev};
    return hi ? id[15:8] : id[7:0];
  endfunction
endpackage

// File: rtl/cfg_port_dec.sv
module cfg_port_dec import cfgp_pkg::*; #(
  parameter logic [15:0] BASE_LO = 16'h002E,
  parameter logic [15:0] BASE_HI = 16'h004E
) (
  input  logic        strap_hi,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  output logic        idx_wr_ev,
  output logic        dat_wr_ev,
  output logic        dat_rd_ev
);
  logic [15:0] base;
  logic        hit_idx, hit_dat;

  always_comb begin
    base      = port_base(strap_hi, BASE_LO, BASE_HI);
    hit_idx   = (io_addr == base);
    hit_dat   = (io_addr == base + 16'd1);
    idx_wr_ev = hit_idx && io_wr;
    dat_wr_ev = hit_dat && io_wr;
    dat_rd_ev = hit_dat && io_rd;
  end
endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm import cfgp_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr_ev,
  input  logic [7:0] io_wdata,
  output logic       key_open,
  output logic       key_half
);
  key_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         st_q <= KS_LOCKED;
    else if (idx_wr_ev) st_q <= next_key(st_q, io_wdata);
  end

  assign key_open = (st_q == KS_OPEN);
  assign key_half = (st_q == KS_HALF);
endmodule

// File: rtl/cfg_bank_route.sv
module cfg_bank_route import cfgp_pkg::*; #(
  parameter int NUM_DEV = 3,
  parameter int DEV_LO  = 7
) (
  input  logic [7:0]           ldn_q,
  input  logic [7:0]           idx_q,
  input  logic                 key_open,
  input  logic                 dat_wr_ev,
  input  logic                 dat_rd_ev,
  input  logic [7:0]           io_wdata,
  input  logic [NUM_DEV*8-1:0] dev_rdata,
  output logic [NUM_DEV-1:0]   dev_sel,
  output logic [7:0]           dev_addr,
  output logic                 dev_wr,
  output logic                 dev_rd,
  output logic [7:0]           dev_wdata,
  output logic [7:0]           bank_data
);
  logic [NUM_DEV-1:0] ldn_match;
  logic               banked, live;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_match
    assign ldn_match[i] = (ldn_q == 8'(DEV_LO + i));
  end

  assign banked    = key_open && (idx_q >= BANK_START);
  assign live      = banked && (|ldn_match);
  assign dev_sel   = banked ? ldn_match : '0;
  assign dev_addr  = idx_q;
  assign dev_wdata = io_wdata;
  assign dev_wr    = live && dat_wr_ev;
  assign dev_rd    = live && dat_rd_ev;

  always_comb begin
    bank_data = NO_DATA;
    for (int i = 0; i < NUM_DEV; i++)
      if (ldn_match[i]) bank_data = dev_rdata[i*8 +: 8];
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl import cfgp_pkg::*; #(
  parameter logic [15:0] BASE_LO     = 16'h002E,
  parameter logic [15:0] BASE_HI     = 16'h004E,
  parameter logic [11:0] CHIP_FAMILY = 12'hA23,
  parameter logic [3:0]  CHIP_REV    = 4'h2,
  parameter int          NUM_DEV     = 3,
  parameter int          DEV_LO      = 7,
  parameter int          GLB_LO      = 34,
  parameter int          GLB_N       = 14,
  localparam int         GLB_W       = GLB_N * 8,
  localparam int         DEV_W       = NUM_DEV * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_hi,
  input  logic [15:0]       io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [GLB_W-1:0]  glb_cfg,
  output logic [NUM_DEV-1:0] dev_sel,
  output logic [7:0]        dev_addr,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [7:0]        dev_wdata,
  input  logic [DEV_W-1:0]  dev_rdata
);
  logic       idx_wr_ev, dat_wr_ev, dat_rd_ev;
  logic       key_open, key_half;
  logic [7:0] idx_q, ldn_q, bank_data, glb_rd;
  logic       glb_hit, cfg_wr;

  cfg_port_dec #(.BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_dec (
    .strap_hi(strap_hi), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .idx_wr_ev(idx_wr_ev), .dat_wr_ev(dat_wr_ev), .dat_rd_ev(dat_rd_ev));

  cfg_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr_ev(idx_wr_ev), .io_wdata(io_wdata),
    .key_open(key_open), .key_half(key_half));

  cfg_bank_route #(.NUM_DEV(NUM_DEV), .DEV_LO(DEV_LO)) u_bank (
    .ldn_q(ldn_q), .idx_q(idx_q), .key_open(key_open),
    .dat_wr_ev(dat_wr_ev), .dat_rd_ev(dat_rd_ev), .io_wdata(io_wdata),
    .dev_rdata(dev_rdata), .dev_sel(dev_sel), .dev_addr(dev_addr),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_wdata(dev_wdata),
    .bank_data(bank_data));

  assign cfg_wr = key_open && dat_wr_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (key_open && idx_wr_ev && io_wdata != KEY_EXIT) idx_q <= io_wdata;
      if (cfg_wr && idx_q == REG_LDN) ldn_q <= io_wdata;
    end
  end

  for (genvar i = 0; i < GLB_N; i++) begin : g_glb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        glb_cfg[i*8 +: 8] <= 8'h00;
      else if (cfg_wr && idx_q == 8'(GLB_LO + i))
        glb_cfg[i*8 +: 8] <= io_wdata;
    end
  end

  always_comb begin
    glb_hit = 1'b0;
    glb_rd  = 8'h00;
    for (int i = 0; i < GLB_N; i++)
      if (idx_q == 8'(GLB_LO + i)) begin
        glb_hit = 1'b1;
        glb_rd  = glb_cfg[i*8 +: 8];
      end
  end

  always_comb begin
    io_rdata = NO_DATA;
    if (dat_rd_ev && key_open) begin
      if (idx_q >= BANK_START)     io_rdata = bank_data;
      else if (idx_q == REG_LDN)   io_rdata = ldn_q;
      else if (idx_q == REG_ID_HI) io_rdata = id_byte(CHIP_FAMILY, CHIP_REV, 1'b1);
      else if (idx_q == REG_ID_LO) io_rdata = id_byte(CHIP_FAMILY, CHIP_REV, 1'b0);
      else if (glb_hit)            io_rdata = glb_rd;
      else                         io_rdata = 8'h00;
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int NUM_DEV = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               key_open,
  input logic               key_half,
  input logic               idx_wr_ev,
  input logic               dat_rd_ev,
  input logic [7:0]         io_wdata,
  input logic [7:0]         io_rdata,
  input logic [7:0]         idx_q,
  input logic [7:0]         ldn_q,
  input logic [NUM_DEV-1:0] dev_sel,
  input logic               dev_wr,
  input logic               dev_rd
);
  AST_ENTER_TWO_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_open) |-> $past(key_half && idx_wr_ev && io_wdata == 8'h87)); // R1

  AST_HALF_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (key_half && idx_wr_ev && io_wdata != 8'h87) |=> (!key_half && !key_open)); // R2

  AST_EXIT_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (key_open && idx_wr_ev && io_wdata == 8'hAA) |=> (!key_open && $stable(idx_q))); // R3

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd_ev && !key_open) |-> io_rdata == 8'hFF); // R4

  AST_LOCKED_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !key_open |=> $stable(ldn_q)); // R4

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel)); // R10

  AST_STROBE_NEEDS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> (key_open && dev_sel != '0)); // R11
endmodule

bind cfg_port_ctrl cfg_port_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_open(key_open), .key_half(key_half),
  .idx_wr_ev(idx_wr_ev), .dat_rd_ev(dat_rd_ev), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .idx_q(idx_q), .ldn_q(ldn_q), .dev_sel(dev_sel),
  .dev_wr(dev_wr), .dev_rd(dev_rd));

// File: tb/sim_cfg_port_ctrl.sv
module sim_cfg_port_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         strap_hi = 1'b0;
  logic [15:0]  io_addr = 16'h0000;
  logic         io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]   io_wdata = 8'h00;
  logic [7:0]   io_rdata;
  logic [111:0] glb_cfg;
  logic [2:0]   dev_sel;
  logic [7:0]   dev_addr, dev_wdata;
  logic         dev_wr, dev_rd;
  logic [23:0]  dev_rdata = {8'hD2, 8'hD1, 8'hD0};

  int checks = 0, errors = 0;
  logic [15:0] base = 16'h002E;
  logic [7:0]  rd_val;
  logic [2:0]  s_sel;
  logic [7:0]  s_addr, s_wdata;
  logic        s_wr, s_rd;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  cfg_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .glb_cfg(glb_cfg), .dev_sel(dev_sel), .dev_addr(dev_addr),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    #2;
    s_sel = dev_sel; s_addr = dev_addr; s_wdata = dev_wdata; s_wr = dev_wr;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2;
    rd_val = io_rdata; s_sel = dev_sel; s_addr = dev_addr; s_rd = dev_rd;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic enter();
    wr(base, 8'h87); wr(base, 8'h87);
  endtask

  task automatic set_reg(input logic [7:0] r, input logic [7:0] d);
    wr(base, r); wr(base + 16'd1, d);
  endtask

  task automatic get_reg(input logic [7:0] r);
    wr(base, r); rd(base + 16'd1);
  endtask

  task automatic t_reset();
    rd(base + 16'd1);
    chk("R6 locked after reset", rd_val, 8'hFF);
    chk("R6 glb_cfg cleared", glb_cfg, 112'h0);
    enter();
    rd(base + 16'd1);
    chk("R6 index 0 after reset (reg 0 reads 0)", rd_val, 8'h00);
    get_reg(8'h07);
    chk("R6 ldn 0 after reset", rd_val, 8'h00);
    wr(base, 8'hAA);
  endtask

  task automatic t_unlock();
    wr(base, 8'h87);
    rd(base + 16'd1);
    chk("R1 one key keeps lock", rd_val, 8'hFF);
    wr(base, 8'h87);
    get_reg(8'h20);
    chk("R1 open after two keys", rd_val, 8'hA2);
    wr(base, 8'hAA);
  endtask

  task automatic t_cancel();
    wr(base, 8'h87); wr(base, 8'h55); wr(base, 8'h87);
    rd(base + 16'd1);
    chk("R2 stray byte cancels sequence", rd_val, 8'hFF);
    wr(base, 8'h87);
    get_reg(8'h21);
    chk("R2 fresh pair reopens", rd_val, 8'h32);
  endtask

  task automatic t_exit_and_id();
    get_reg(8'h21);
    chk("R7 id low byte", rd_val, 8'h32);
    wr(base + 16'd1, 8'h00);
    get_reg(8'h20);
    chk("R7 id high byte", rd_val, 8'hA2);
    wr(base + 16'd1, 8'h13);
    rd(base + 16'd1);
    chk("R7 id write ignored", rd_val, 8'hA2);
    wr(base, 8'h21);
    wr(base, 8'hAA);
    rd(base + 16'd1);
    chk("R3 exit key locks", rd_val, 8'hFF);
    enter();
    rd(base + 16'd1);
    chk("R3 index kept across exit", rd_val, 8'h32);
  endtask

  task automatic t_global();
    set_reg(8'h22, 8'h11);
    set_reg(8'h2F, 8'h9C);
    chk("R9 glb byte 0x22", glb_cfg[7:0], 8'h11);
    chk("R9 glb byte 0x2F", glb_cfg[111:104], 8'h9C);
    get_reg(8'h2F);
    chk("R9 glb readback", rd_val, 8'h9C);
    set_reg(8'h10, 8'h33);
    rd(base + 16'd1);
    chk("R9 unused global reads 0", rd_val, 8'h00);
    wr(base, 8'h22);
    wr(base, 8'hAA);
    wr(base + 16'd1, 8'h99);
    wr(base, 8'h07);
    wr(base + 16'd1, 8'h08);
    chk("R4 locked write leaves glb", glb_cfg[7:0], 8'h11);
    enter();
    rd(base + 16'd1);
    chk("R4 locked index write ignored", rd_val, 8'h11);
    get_reg(8'h07);
    chk("R4 locked data write left ldn", rd_val, 8'h00);
  endtask

  task automatic t_bank();
    set_reg(8'h07, 8'h08);
    get_reg(8'h07);
    chk("R8 ldn readback", rd_val, 8'h08);
    get_reg(8'h30);
    chk("R10 dev1 read data", rd_val, 8'hD1);
    chk("R10 dev1 rd strobe", s_rd, 1'b1);
    chk("R10 dev1 select", s_sel, 3'b010);
    chk("R10 dev addr", s_addr, 8'h30);
    wr(base, 8'hE1);
    wr(base + 16'd1, 8'h5C);
    chk("R10 write bus", {s_wr, s_sel, s_addr, s_wdata}, {1'b1, 3'b010, 8'hE1, 8'h5C});
    set_reg(8'h07, 8'h07);
    get_reg(8'hF0);
    chk("R10 dev0 read", {s_sel, rd_val}, {3'b001, 8'hD0});
    set_reg(8'h07, 8'h09);
    get_reg(8'h30);
    chk("R10 dev2 read", {s_sel, rd_val}, {3'b100, 8'hD2});
  endtask

  task automatic t_nodev();
    set_reg(8'h07, 8'h0B);
    get_reg(8'h30);
    chk("R11 no device reads FF", rd_val, 8'hFF);
    chk("R11 no rd strobe", {s_rd, s_sel}, 4'b0);
    wr(base + 16'd1, 8'h44);
    chk("R11 no wr strobe", {s_wr, s_sel}, 4'b0);
    get_reg(8'h2F);
    chk("R11 globals still reachable", rd_val, 8'h9C);
  endtask

  task automatic t_strap();
    wr(base, 8'h20);
    strap_hi = 1'b1;
    wr(16'h002E, 8'hAA);
    rd(16'h004F);
    chk("R5 old base ignored, new base reads", rd_val, 8'hA2);
    rd(16'h002F);
    chk("R5 old data port reads FF", rd_val, 8'hFF);
    rd(16'h004E);
    chk("R5 index port reads FF", rd_val, 8'hFF);
    wr(16'h004E, 8'hAA);
    rd(16'h004F);
    chk("R5 exit at high base", rd_val, 8'hFF);
    strap_hi = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlock();
    t_cancel();
    t_exit_and_id();
    t_global();
    t_bank();
    t_nodev();
    t_strap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule